// File: doc/BRIEF.md
# SRAM Power-Up Initialization Sequencer

This block sits on the controller side of an external synchronous SRAM. It takes the memory from power-up to a state where commands are allowed. It holds the memory reset output high for a minimum hold time and until the controller reports that its clocks are stable. It then releases reset and waits out the impedance calibration interval. Next it turns on the memory's DLL enable, unless that enable was already requested during calibration. It then waits out the DLL lock interval and finally raises `init_done`. The three intervals are parameters. Production builds use the full cycle counts, and simulation can shrink them.

The command path is a valid/ready stream that passes through the block. Before `init_done` the stream is closed: `req_ready` and `fwd_valid` are both low whatever the requester does. After `init_done` the block is transparent. `fwd_valid` follows `req_valid`, `fwd_cmd` follows `req_cmd`, and back-pressure from `fwd_ready` reaches `req_ready` in the same cycle. A command transfers on a cycle in which `req_valid` and `req_ready` are both high. The requester must hold `req_cmd` steady while `req_valid` is high and `req_ready` is low.

The `dll_early` input chooses between two orderings. When it is high during calibration, `dll_en` rises together with the release of reset, and the lock wait starts directly when calibration ends. When it is low, `dll_en` rises one cycle after calibration ends, and the lock wait follows. If `clk_stable` drops at any point before `init_done`, the sequence starts again from the reset-held state. Once `init_done` is high, only `rst_n` ends it.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous), `mem_rst`=1, `dll_en`=0, `init_done`=0, `req_ready`=0 and `fwd_valid`=0.
- R2: After `rst_n` is released with `clk_stable` high, `mem_rst` stays high for exactly RST_CYC cycles. While `mem_rst` is high, `dll_en` and `init_done` are low.
- R3: `mem_rst` stays high for as long as `clk_stable` is low. Once the hold time is met, `mem_rst` falls one cycle after `clk_stable` is seen high.
- R4: With `dll_early` low, `mem_rst`, `dll_en` and `init_done` are all low during calibration. `dll_en` rises exactly CAL_CYC cycles after `mem_rst` falls.
- R5: With `dll_early` low, `init_done` rises exactly LOCK_CYC+1 cycles after `dll_en` rises. Whenever `init_done` is high, `dll_en` is high, and `dll_en` has been high for at least LOCK_CYC cycles.
- R6: With `dll_early` high during calibration, `dll_en` rises in the same cycle that `mem_rst` falls. `init_done` rises exactly CAL_CYC+LOCK_CYC cycles after `mem_rst` falls.
- R7: If `clk_stable` is low while `mem_rst` is low and `init_done` is low, then in the next cycle `mem_rst` is high and `dll_en` is low. The full RST_CYC hold then applies again before the sequence resumes.
- R8: While `init_done` is low, `req_ready`=0 and `fwd_valid`=0, whatever the value of `req_valid`.
- R9: While `init_done` is high, `fwd_valid` equals `req_valid`, `fwd_cmd` equals `req_cmd`, and `req_ready` equals `fwd_ready`.
- R10: Once `init_done` is high, `clk_stable` has no effect. `init_done` and `dll_en` stay high and `mem_rst` stays low until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| clk_stable | input | 1 | High when the memory clocks are within specification |
| dll_early | input | 1 | High requests DLL enable during calibration |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Command request accepted |
| req_cmd | input | CMD_W | Command payload |
| fwd_valid | output | 1 | Command forwarded to the memory interface |
| fwd_ready | input | 1 | Memory interface can take a command |
| fwd_cmd | output | CMD_W | Forwarded command payload |
| mem_rst | output | 1 | Memory reset, active high |
| dll_en | output | 1 | Memory DLL enable |
| init_done | output | 1 | Initialization complete; commands allowed |

## Verification
The sequence runs under three stimulus patterns. The first keeps clocks stable with a late DLL enable, which separates the hold, calibration and lock intervals by the exact cycle of each edge. The second keeps clocks unstable past the hold time and uses an early DLL enable. This shows that release waits on `clk_stable` and that the separate DLL-on cycle is skipped. The third drops `clk_stable` during the lock wait, which shows that the restart clears the hold count instead of resuming. A scoreboard compares every output edge with its expected cycle. Commands offered before and after ready, with and without back-pressure, separate gating from pass-through.

// File: rtl/pus_pkg.sv
package pus_pkg;
  typedef enum logic [2:0] {
    ST_RST   = 3'd0,
    ST_CAL   = 3'd1,
    ST_DLLON = 3'd2,
    ST_LOCK  = 3'd3,
    ST_RDY   = 3'd4
  } pus_state_e;
endpackage

// File: rtl/pus_timer.sv
// Cycle counter shared by all wait states; cleared on every state change,
// saturates at its maximum so a long clock-unstable wait cannot wrap.
module pus_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pus_fsm.sv
module pus_fsm
  import pus_pkg::*;
#(
  parameter int W        = 8,
  parameter int RST_CYC  = 4,
  parameter int CAL_CYC  = 4,
  parameter int LOCK_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_stable,
  input  logic         dll_early,
  input  logic [W-1:0] cnt,
  output pus_state_e   st,
  output logic         clr
);
  // A state lasting N cycles leaves when the count reaches N-1.
  localparam logic [W-1:0] RST_LAST  = W'(RST_CYC - 1);
  localparam logic [W-1:0] CAL_LAST  = W'(CAL_CYC - 1);
  localparam logic [W-1:0] LOCK_LAST = W'(LOCK_CYC - 1);

  pus_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_RST:   if (clk_stable && cnt >= RST_LAST) nxt = ST_CAL;
      ST_CAL:   if (!clk_stable)                 nxt = ST_RST;
                else if (cnt >= CAL_LAST)        nxt = dll_early ? ST_LOCK : ST_DLLON;
      ST_DLLON: nxt = clk_stable ? ST_LOCK : ST_RST;
      ST_LOCK:  if (!clk_stable)                 nxt = ST_RST;
                else if (cnt >= LOCK_LAST)       nxt = ST_RDY;
      ST_RDY:   nxt = ST_RDY;
      default:  nxt = ST_RST;
    endcase
  end

  assign clr = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RST;
    else        st <= nxt;
  end
endmodule

// File: rtl/pus_gate.sv
// Decodes the memory control pins from the state and closes the command
// stream until initialization is complete.
module pus_gate
  import pus_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  pus_state_e       st,
  input  logic             dll_early,
  input  logic             req_valid,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic             fwd_ready,
  output logic             req_ready,
  output logic             fwd_valid,
  output logic [CMD_W-1:0] fwd_cmd,
  output logic             mem_rst,
  output logic             dll_en,
  output logic             init_done
);
  logic open;

  assign open      = (st == ST_RDY);
  assign init_done = open;
  assign mem_rst   = (st == ST_RST);
  assign dll_en    = (st == ST_DLLON) || (st == ST_LOCK) || open ||
                     ((st == ST_CAL) && dll_early);

  assign fwd_valid = open && req_valid;
  assign req_ready = open && fwd_ready;
  assign fwd_cmd   = req_cmd;
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pus_pkg::*;
#(
  parameter int RST_CYC  = 50000,
  parameter int CAL_CYC  = 163840,
  parameter int LOCK_CYC = 65536,
  parameter int CMD_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_stable,
  input  logic             dll_early,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CMD_W-1:0] req_cmd,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output logic [CMD_W-1:0] fwd_cmd,
  output logic             mem_rst,
  output logic             dll_en,
  output logic             init_done
);
  localparam int MAX_A = (RST_CYC > CAL_CYC) ? RST_CYC : CAL_CYC;
  localparam int MAX_C = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1) + 1;

  pus_state_e       st;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  pus_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt)
  );

  pus_fsm #(
    .W(CNT_W), .RST_CYC(RST_CYC), .CAL_CYC(CAL_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .dll_early(dll_early),
    .cnt(cnt), .st(st), .clr(clr)
  );

  pus_gate #(.CMD_W(CMD_W)) u_gate (
    .st(st), .dll_early(dll_early), .req_valid(req_valid), .req_cmd(req_cmd),
    .fwd_ready(fwd_ready), .req_ready(req_ready), .fwd_valid(fwd_valid),
    .fwd_cmd(fwd_cmd), .mem_rst(mem_rst), .dll_en(dll_en), .init_done(init_done)
  );
endmodule

// File: rtl/pus_chk.sv
module pus_chk #(
  parameter int CAL_CYC  = 4,
  parameter int LOCK_CYC = 4,
  parameter int CMD_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_stable,
  input logic             mem_rst,
  input logic             dll_en,
  input logic             init_done,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CMD_W-1:0] req_cmd,
  input logic             fwd_valid,
  input logic             fwd_ready,
  input logic [CMD_W-1:0] fwd_cmd
);
  localparam int CW = $clog2(CAL_CYC + LOCK_CYC + 2) + 1;

  // Window counters: edges seen with reset low, and with DLL enabled.
  logic [CW-1:0] low_cnt, dll_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_cnt <= '0;
    else if (mem_rst)         low_cnt <= '0;
    else if (low_cnt != '1)   low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               dll_cnt <= '0;
    else if (!dll_en)         dll_cnt <= '0;
    else if (dll_cnt != '1)   dll_cnt <= dll_cnt + 1'b1;
  end

  p_rst_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rst |-> (!dll_en && !init_done));

  p_release_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rst) |-> $past(clk_stable));

  p_cal_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (low_cnt >= CW'(CAL_CYC)));

  p_lock_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (dll_en && dll_cnt >= CW'(LOCK_CYC)));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !mem_rst && !clk_stable) |=> (mem_rst && !dll_en));

  p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!fwd_valid && !req_ready));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (fwd_valid == req_valid && req_ready == fwd_ready &&
                   (!req_valid || fwd_cmd == req_cmd)));

  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && !mem_rst));
endmodule

bind pwrup_seq pus_chk #(
  .CAL_CYC(CAL_CYC), .LOCK_CYC(LOCK_CYC), .CMD_W(CMD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .mem_rst(mem_rst),
  .dll_en(dll_en), .init_done(init_done), .req_valid(req_valid),
  .req_ready(req_ready), .req_cmd(req_cmd), .fwd_valid(fwd_valid),
  .fwd_ready(fwd_ready), .fwd_cmd(fwd_cmd)
);

// File: tb/sim_pwrup_seq.sv
module sim_pwrup_seq;
  localparam int RC = 20;
  localparam int CC = 40;
  localparam int LC = 30;
  localparam int CW = 8;

  localparam int EV_RST_RISE = 0;
  localparam int EV_RST_FALL = 1;
  localparam int EV_DLL_RISE = 2;
  localparam int EV_DLL_FALL = 3;
  localparam int EV_RDY_RISE = 4;
  localparam int EV_RDY_FALL = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, clk_stable, dll_early, req_valid, fwd_ready;
  logic [CW-1:0] req_cmd, fwd_cmd;
  logic          req_ready, fwd_valid, mem_rst, dll_en, init_done;

  pwrup_seq #(.RST_CYC(RC), .CAL_CYC(CC), .LOCK_CYC(LC), .CMD_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .dll_early(dll_early),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_cmd(fwd_cmd),
    .mem_rst(mem_rst), .dll_en(dll_en), .init_done(init_done)
  );

  typedef struct {
    int    kind;
    int    at;
    string req;
  } ev_t;

  ev_t expq[$];
  int  tick   = 0;
  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, int at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  // Monitor: compares each observed output edge against the scoreboard.
  task automatic got(int kind);
    ev_t e;
    n_chk++;
    if (expq.size() == 0) begin
      n_fail++;
      $display("FAIL R10 unexpected edge: actual kind %0d at %0d expected none", kind, tick);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.at != tick) begin
        n_fail++;
        $display("FAIL %s edge: actual kind %0d at %0d expected kind %0d at %0d",
                 e.req, kind, tick, e.kind, e.at);
      end
    end
  endtask

  logic p_rst = 1'b1, p_dll = 1'b0, p_rdy = 1'b0;
  always begin
    @(posedge clk);
    #5;
    tick++;
    if ( mem_rst   && !p_rst) got(EV_RST_RISE);
    if (!mem_rst   &&  p_rst) got(EV_RST_FALL);
    if ( dll_en    && !p_dll) got(EV_DLL_RISE);
    if (!dll_en    &&  p_dll) got(EV_DLL_FALL);
    if ( init_done && !p_rdy) got(EV_RDY_RISE);
    if (!init_done &&  p_rdy) got(EV_RDY_FALL);
    p_rst = mem_rst; p_dll = dll_en; p_rdy = init_done;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tick(int t);
    while (tick < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int k, k1, k2;
    rst_n = 1'b0; clk_stable = 1'b1; dll_early = 1'b0;
    req_valid = 1'b0; req_cmd = '0; fwd_ready = 1'b1;

    // ---- Scenario A: stable clocks, late DLL enable
    cyc(3);
    chk("R1", "mem_rst", mem_rst, 1);
    chk("R1", "dll_en", dll_en, 0);
    chk("R1", "init_done", init_done, 0);
    chk("R1", "req_ready", req_ready, 0);
    k = tick;
    rst_n = 1'b1;
    expect_ev(EV_RST_FALL, k + RC, "R2");
    expect_ev(EV_DLL_RISE, k + RC + CC, "R4");
    expect_ev(EV_RDY_RISE, k + RC + CC + LC + 1, "R5");
    cyc(5);
    req_valid = 1'b1; req_cmd = 8'hA5;
    #1;
    chk("R8", "fwd_valid during reset", fwd_valid, 0);
    chk("R8", "req_ready during reset", req_ready, 0);
    chk("R2", "dll_en during reset", dll_en, 0);
    wait_tick(k + RC + 15);
    chk("R4", "mem_rst in calibration", mem_rst, 0);
    chk("R4", "dll_en in calibration", dll_en, 0);
    chk("R8", "fwd_valid in calibration", fwd_valid, 0);
    wait_tick(k + RC + CC + LC + 3);
    chk("R9", "fwd_valid open", fwd_valid, 1);
    chk("R9", "fwd_cmd", fwd_cmd, 8'hA5);
    chk("R9", "req_ready open", req_ready, 1);
    fwd_ready = 1'b0; req_cmd = 8'h3C;
    #1;
    chk("R9", "req_ready back-pressure", req_ready, 0);
    chk("R9", "fwd_valid held", fwd_valid, 1);
    chk("R9", "fwd_cmd held", fwd_cmd, 8'h3C);
    cyc(1);
    req_valid = 1'b0; fwd_ready = 1'b1;
    #1;
    chk("R9", "fwd_valid idle", fwd_valid, 0);
    clk_stable = 1'b0;
    cyc(6);
    chk("R10", "init_done after clock loss", init_done, 1);
    chk("R10", "mem_rst after clock loss", mem_rst, 0);
    chk("R10", "dll_en after clock loss", dll_en, 1);
    clk_stable = 1'b1;
    cyc(1);
    k = tick;
    rst_n = 1'b0;
    expect_ev(EV_RST_RISE, k + 1, "R1");
    expect_ev(EV_DLL_FALL, k + 1, "R1");
    expect_ev(EV_RDY_FALL, k + 1, "R1");
    #1;
    chk("R1", "fwd_valid in reset", fwd_valid, 0);

    // ---- Scenario B: clocks unstable past hold time, early DLL enable
    cyc(2);
    clk_stable = 1'b0; dll_early = 1'b1;
    cyc(1);
    rst_n = 1'b1;
    cyc(50);
    chk("R3", "mem_rst while clocks unstable", mem_rst, 1);
    k1 = tick;
    clk_stable = 1'b1;
    expect_ev(EV_RST_FALL, k1 + 1, "R3");
    expect_ev(EV_DLL_RISE, k1 + 1, "R6");
    expect_ev(EV_RDY_RISE, k1 + 1 + CC + LC, "R6");
    cyc(6);
    chk("R6", "dll_en in calibration", dll_en, 1);
    chk("R6", "init_done in calibration", init_done, 0);
    wait_tick(k1 + CC + LC + 4);
    k = tick;
    rst_n = 1'b0;
    expect_ev(EV_RST_RISE, k + 1, "R1");
    expect_ev(EV_DLL_FALL, k + 1, "R1");
    expect_ev(EV_RDY_FALL, k + 1, "R1");

    // ---- Scenario C: clock loss during lock wait restarts the sequence
    cyc(2);
    dll_early = 1'b0;
    k = tick;
    rst_n = 1'b1;
    expect_ev(EV_RST_FALL, k + RC, "R2");
    expect_ev(EV_DLL_RISE, k + RC + CC, "R4");
    wait_tick(k + RC + CC + 5);
    k2 = tick;
    clk_stable = 1'b0;
    expect_ev(EV_RST_RISE, k2 + 1, "R7");
    expect_ev(EV_DLL_FALL, k2 + 1, "R7");
    cyc(3);
    clk_stable = 1'b1;
    expect_ev(EV_RST_FALL, k2 + 1 + RC, "R7");
    expect_ev(EV_DLL_RISE, k2 + 1 + RC + CC, "R4");
    expect_ev(EV_RDY_RISE, k2 + 1 + RC + CC + 1 + LC, "R5");
    cyc(2);
    chk("R7", "mem_rst after restart", mem_rst, 1);
    chk("R7", "init_done after restart", init_done, 0);
    req_valid = 1'b1; req_cmd = 8'h5A;
    wait_tick(k2 + RC + CC + LC + 5);
    chk("R9", "fwd_valid after restart", fwd_valid, 1);
    chk("R9", "fwd_cmd after restart", fwd_cmd, 8'h5A);
    cyc(2);
    chk("R5", "scoreboard drained", expq.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule